// File: doc/BRIEF.md
# Dual-Inbox Halfword Mailbox

This block passes 32-bit messages between two processors over a 16-bit register interface. It has three single-entry channels. The outbound channel carries messages from the host processor to the peer processor. Two inbound channels carry messages from the peer to the host. Each processor has its own bus port, and both ports share one address map.

A message is moved in two halfword accesses. The sender writes the low half of the message to the channel's data register and then writes the high half to its command register. The command write commits the message: it raises the channel's pending flag, and that flag drives the interrupt toward the receiving processor. The receiver reads the data register and then the command register. The command read consumes the message: it drops the flag and the interrupt.

A channel stores exactly one message, so each interrupt stands for one message. Only the receive side has an interrupt. Read data is combinational from the address while the read strobe is high. Writes and consumes take effect at the clock edge.

Top module: `mbox_dual_inbox`

## Requirements
- R1: Reset (active-low `rst_n`) clears every data, command and flag register and holds all three interrupts low.
- R2: The byte addresses are fixed. Outbound data is 0x00 and command is 0x04. Inbound-1 data is 0x08 and command is 0x0C. Inbound-2 data is 0x10 and command is 0x14. The flags are 0x18 (outbound), 0x1C (inbound-1) and 0x20 (inbound-2). A read of any other address, including an address that is not a multiple of four, returns 0x0000.
- R3: When the sender writes a channel's command register, that value is stored, the flag reads 0x0001 and the channel's interrupt is high from the next cycle on. The interrupt for the outbound channel is `irq_peer`. The interrupts for the inbound channels are `irq_host1` and `irq_host2`.
- R4: A write to a data register stores the value but changes neither the flag nor the interrupt.
- R5: When the receiver reads a channel's command register, the stored value appears in the same cycle, and the flag and the interrupt are low from the next cycle on. Reading a data register does not consume the message.
- R6: The whole 32-bit message is the command register in bits 31:16 and the data register in bits 15:0. Both halves keep their values after the message is consumed.
- R7: The host writes only the outbound channel, and the peer writes only the two inbound channels. A write to the other side's channel, or to any flag address, changes no register.
- R8: A command read by the sending side returns the value but leaves the flag and the interrupt set.
- R9: If a command write and a consuming command read hit the same channel in the same cycle, the read returns the old value, and afterwards the new value is stored and the flag stays set.
- R10: A second command write before the message is consumed overwrites the command register and leaves a single pending message. One consuming read clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | AW (6) | Host byte address |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | HW (16) | Host write data |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | HW (16) | Host read data, 0 when not reading |
| peer_addr | input | AW (6) | Peer byte address |
| peer_wr | input | 1 | Peer write strobe |
| peer_wdata | input | HW (16) | Peer write data |
| peer_rd | input | 1 | Peer read strobe |
| peer_rdata | output | HW (16) | Peer read data, 0 when not reading |
| irq_peer | output | 1 | Outbound message pending, toward the peer |
| irq_host1 | output | 1 | Inbound-1 message pending, toward the host |
| irq_host2 | output | 1 | Inbound-2 message pending, toward the host |

## Verification
The stimulus table runs full send and receive sequences on each channel. These tell a data write apart from a command write, and a data read apart from a command read. Reads by the sending side and writes from the wrong side show whether ownership and the consuming read are decoded per side rather than per address. Back-to-back command writes, together with reads of misaligned, unmapped and flag addresses, separate single-entry overwrite from queuing and expose loose decode. Directed cases then cover a write and a consume landing on the same edge, and a reset in the middle of traffic.

// File: rtl/mbox_dual_inbox.sv
module mbox_dual_inbox #(
  parameter int AW = 6,
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] host_addr,
  input  logic          host_wr,
  input  logic [HW-1:0] host_wdata,
  input  logic          host_rd,
  output logic [HW-1:0] host_rdata,
  input  logic [AW-1:0] peer_addr,
  input  logic          peer_wr,
  input  logic [HW-1:0] peer_wdata,
  input  logic          peer_rd,
  output logic [HW-1:0] peer_rdata,
  output logic          irq_peer,
  output logic          irq_host1,
  output logic          irq_host2
);
  localparam int NCH      = 3;
  localparam int CH_STEP  = 8;
  localparam int FLG_BASE = NCH * CH_STEP;

  logic [HW-1:0] data_q [NCH];
  logic [HW-1:0] cmd_q  [NCH];
  logic [NCH-1:0] flag_q;

  logic [NCH-1:0] h_dat, h_cmd, h_flg, p_dat, p_cmd, p_flg;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [AW-1:0] A_DAT = AW'(c * CH_STEP);
    localparam logic [AW-1:0] A_CMD = AW'(c * CH_STEP + 4);
    localparam logic [AW-1:0] A_FLG = AW'(FLG_BASE + c * 4);

    assign h_dat[c] = host_addr == A_DAT;
    assign h_cmd[c] = host_addr == A_CMD;
    assign h_flg[c] = host_addr == A_FLG;
    assign p_dat[c] = peer_addr == A_DAT;
    assign p_cmd[c] = peer_addr == A_CMD;
    assign p_flg[c] = peer_addr == A_FLG;

    wire          snd_wr  = (c == 0) ? host_wr    : peer_wr;
    wire [HW-1:0] snd_wd  = (c == 0) ? host_wdata : peer_wdata;
    wire          wr_dat  = snd_wr && ((c == 0) ? h_dat[c] : p_dat[c]);
    wire          wr_cmd  = snd_wr && ((c == 0) ? h_cmd[c] : p_cmd[c]);
    wire          consume = (c == 0) ? (peer_rd && p_cmd[c]) : (host_rd && h_cmd[c]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q[c] <= '0;
        cmd_q[c]  <= '0;
        flag_q[c] <= 1'b0;
      end else begin
        if (wr_dat) data_q[c] <= snd_wd;
        if (wr_cmd) cmd_q[c]  <= snd_wd;
        if (wr_cmd)       flag_q[c] <= 1'b1;
        else if (consume) flag_q[c] <= 1'b0;
      end
    end
  end

  always_comb begin
    host_rdata = '0;
    peer_rdata = '0;
    for (int c = 0; c < NCH; c++) begin
      if (host_rd) begin
        if (h_dat[c]) host_rdata = data_q[c];
        if (h_cmd[c]) host_rdata = cmd_q[c];
        if (h_flg[c]) host_rdata = HW'(flag_q[c]);
      end
      if (peer_rd) begin
        if (p_dat[c]) peer_rdata = data_q[c];
        if (p_cmd[c]) peer_rdata = cmd_q[c];
        if (p_flg[c]) peer_rdata = HW'(flag_q[c]);
      end
    end
  end

  assign irq_peer  = flag_q[0];
  assign irq_host1 = flag_q[1];
  assign irq_host2 = flag_q[2];
endmodule

module mbox_dual_inbox_chk #(
  parameter int AW = 6,
  parameter int HW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] host_addr,
  input logic          host_wr,
  input logic [HW-1:0] host_wdata,
  input logic          host_rd,
  input logic [HW-1:0] host_rdata,
  input logic [AW-1:0] peer_addr,
  input logic          peer_wr,
  input logic [HW-1:0] peer_wdata,
  input logic          peer_rd,
  input logic [HW-1:0] peer_rdata,
  input logic          irq_peer,
  input logic          irq_host1,
  input logic          irq_host2
);
  localparam logic [AW-1:0] CMD0 = AW'(4);
  localparam logic [AW-1:0] DAT1 = AW'(8);
  localparam logic [AW-1:0] CMD1 = AW'(12);

  wire h_cmd0_w = host_wr && host_addr == CMD0;
  wire p_cmd0_r = peer_rd && peer_addr == CMD0;
  wire p_cmd1_w = peer_wr && peer_addr == CMD1;
  wire h_cmd1_r = host_rd && host_addr == CMD1;

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !irq_peer && !irq_host1 && !irq_host2);

  assert_commit_raises_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    h_cmd0_w |=> irq_peer);

  assert_data_write_no_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (peer_wr && peer_addr == DAT1 && !h_cmd1_r) |=> $stable(irq_host1));

  assert_consume_drops_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (h_cmd1_r && !p_cmd1_w) |=> !irq_host1);

  assert_foreign_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == CMD1 && !p_cmd1_w && !h_cmd1_r) |=> $stable(irq_host1));

  assert_sender_read_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == CMD0 && !p_cmd0_r) |=> (irq_peer || !$past(irq_peer)));

  assert_set_beats_consume_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (h_cmd0_w && p_cmd0_r) |=> irq_peer);
endmodule

bind mbox_dual_inbox mbox_dual_inbox_chk #(.AW(AW), .HW(HW)) u_chk (.*);

// File: tb/tb_mbox_dual_inbox.sv
module tb_mbox_dual_inbox;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0]  host_addr = '0, peer_addr = '0;
  logic        host_wr = 1'b0, host_rd = 1'b0, peer_wr = 1'b0, peer_rd = 1'b0;
  logic [15:0] host_wdata = '0, peer_wdata = '0;
  logic [15:0] host_rdata, peer_rdata;
  logic        irq_peer, irq_host1, irq_host2;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mbox_dual_inbox dut (.*);

  // side(1) rd(1) addr(6) wdata(16) exp_rdata(16) exp_irq{host2,host1,peer}(3) tag(16)
  function automatic logic [58:0] V(input bit s, input bit r, input logic [5:0] a,
      input logic [15:0] w, input logic [15:0] e, input logic [2:0] i, input logic [15:0] t);
    return {s, r, a, w, e, i, t};
  endfunction

  localparam int NV = 31;
  localparam logic [58:0] VEC [NV] = '{
    V(0,0,6'h00,16'h1234,16'h0000,3'b000,"R4"),
    V(1,1,6'h18,16'h0000,16'h0000,3'b000,"R4"),
    V(0,0,6'h04,16'hABCD,16'h0000,3'b001,"R3"),
    V(1,1,6'h18,16'h0000,16'h0001,3'b001,"R3"),
    V(0,1,6'h1C,16'h0000,16'h0000,3'b001,"R2"),
    V(1,1,6'h00,16'h0000,16'h1234,3'b001,"R5"),
    V(1,1,6'h04,16'h0000,16'hABCD,3'b000,"R5"),
    V(1,1,6'h18,16'h0000,16'h0000,3'b000,"R5"),
    V(1,0,6'h08,16'h5555,16'h0000,3'b000,"R4"),
    V(1,0,6'h0C,16'h0101,16'h0000,3'b010,"R3"),
    V(1,0,6'h10,16'hAAAA,16'h0000,3'b010,"R4"),
    V(1,0,6'h14,16'h0202,16'h0000,3'b110,"R3"),
    V(0,1,6'h1C,16'h0000,16'h0001,3'b110,"R2"),
    V(0,1,6'h20,16'h0000,16'h0001,3'b110,"R2"),
    V(1,1,6'h0C,16'h0000,16'h0101,3'b110,"R8"),
    V(0,1,6'h08,16'h0000,16'h5555,3'b110,"R6"),
    V(0,1,6'h0C,16'h0000,16'h0101,3'b100,"R6"),
    V(0,1,6'h10,16'h0000,16'hAAAA,3'b100,"R6"),
    V(0,1,6'h14,16'h0000,16'h0202,3'b000,"R6"),
    V(0,0,6'h0C,16'h7777,16'h0000,3'b000,"R7"),
    V(0,1,6'h0C,16'h0000,16'h0101,3'b000,"R7"),
    V(1,0,6'h04,16'h9999,16'h0000,3'b000,"R7"),
    V(1,1,6'h04,16'h0000,16'hABCD,3'b000,"R7"),
    V(0,0,6'h1C,16'hFFFF,16'h0000,3'b000,"R7"),
    V(0,1,6'h1C,16'h0000,16'h0000,3'b000,"R7"),
    V(0,1,6'h02,16'h0000,16'h0000,3'b000,"R2"),
    V(0,1,6'h24,16'h0000,16'h0000,3'b000,"R2"),
    V(1,0,6'h14,16'h1111,16'h0000,3'b100,"R10"),
    V(1,0,6'h14,16'h2222,16'h0000,3'b100,"R10"),
    V(0,1,6'h14,16'h0000,16'h2222,3'b000,"R10"),
    V(0,1,6'h20,16'h0000,16'h0000,3'b000,"R10")
  };

  task automatic check(input bit ok, input logic [23:0] tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    host_wr = 0; host_rd = 0; peer_wr = 0; peer_rd = 0;
  endtask

  function automatic logic [2:0] irqs();
    return {irq_host2, irq_host1, irq_peer};
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(irqs() == 3'b000, "R1", {13'b0, irqs()}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: every register reads zero after reset
    for (int a = 0; a <= 'h20; a += 4) begin
      host_addr = 6'(a); host_rd = 1;
      #1 check(host_rdata == 16'h0, "R1", host_rdata, 16'h0);
      @(negedge clk);
    end
    idle();
    check(irqs() == 3'b000, "R1", {13'b0, irqs()}, 16'h0);

    for (int k = 0; k < NV; k++) begin
      logic [58:0] v;
      v = VEC[k];
      @(negedge clk);
      idle();
      if (v[58]) begin
        peer_addr = v[56:51]; peer_wdata = v[50:35];
        peer_wr = ~v[57]; peer_rd = v[57];
      end else begin
        host_addr = v[56:51]; host_wdata = v[50:35];
        host_wr = ~v[57]; host_rd = v[57];
      end
      #1;
      if (v[57]) begin
        logic [15:0] got;
        got = v[58] ? peer_rdata : host_rdata;
        check(got == v[34:19], {v[15:0], 8'h20}, got, v[34:19]);
      end
      @(negedge clk);
      idle();
      check(irqs() == v[18:16], {v[15:0], 8'h20}, {13'b0, irqs()}, {13'b0, v[18:16]});
    end

    // R9: commit and consume on the outbound channel in the same cycle
    @(negedge clk);
    host_addr = 6'h04; host_wdata = 16'h4444; host_wr = 1;
    peer_addr = 6'h04; peer_rd = 1;
    #1 check(peer_rdata == 16'hABCD, "R9", peer_rdata, 16'hABCD);
    @(negedge clk);
    idle();
    check(irq_peer == 1'b1, "R9", {15'b0, irq_peer}, 16'h1);
    peer_addr = 6'h04; peer_rd = 1;
    #1 check(peer_rdata == 16'h4444, "R9", peer_rdata, 16'h4444);
    @(negedge clk);
    idle();
    check(irq_peer == 1'b0, "R5", {15'b0, irq_peer}, 16'h0);

    // R1: reset during traffic
    peer_addr = 6'h14; peer_wdata = 16'h3333; peer_wr = 1;
    @(negedge clk);
    idle();
    check(irq_host2 == 1'b1, "R3", {15'b0, irq_host2}, 16'h1);
    rst_n = 1'b0;
    #1 check(irqs() == 3'b000, "R1", {13'b0, irqs()}, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;
    host_addr = 6'h14; host_rd = 1;
    #1 check(host_rdata == 16'h0, "R1", host_rdata, 16'h0);
    @(negedge clk);
    idle();

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule